// File: doc/BRIEF.md
# Programmable Two-Digit Divide-by-N Counter

This block divides its clock by a programmed ratio N. It is a synchronous down counter built from two 4-bit digit stages. Each stage counts either in binary (0 to 15) or in BCD (0 to 9), and a separate mode pin sets the code of each stage. The count runs down from the programmed value. When it reaches 1, the next edge loads the preset again. The count therefore never rests at zero, and one full cycle lasts exactly N clocks.

A one-clock pulse on `zero_det` marks each cycle, so the block can act as a programmable prescaler or as the front of a longer divider chain. `q_out` is the top bit of the upper stage.

When `load_en` is low, the preset is ignored and the chain always reloads zero. It then runs at its full natural modulus. That modulus is 256, 160 or 100, depending on the two mode pins. All pins are plain control and status signals and follow a single clock domain. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `dvn_divider`

## Requirements
- R1: The lower stage decrements on every clock that is not a reload clock. The upper stage changes only when the lower stage borrows, which happens when the lower stage steps down from 0.
- R2: Each stage has its own code. `bcd_mode[0]` sets the lower stage and `bcd_mode[1]` sets the upper stage, with 1 meaning BCD and 0 meaning binary. A BCD stage at 0 that borrows wraps to 9. A binary stage at 0 that borrows wraps to 15.
- R3: Take a nonzero preset with upper digit u = `preset[7:4]` and lower digit l = `preset[3:0]`. The distance between `zero_det` pulses is u*M + l clocks, where M is 10 if the lower stage is BCD and 16 if it is binary.
- R4: `zero_det` is high for exactly one clock per cycle and low on every other clock.
- R5: A preset of 0 gives the full modulus: 256 with both stages binary, 160 with one stage BCD, and 100 with both stages BCD.
- R6: While `load_en` is low, the preset has no effect, including a preset changed mid-run. The ratio is the full modulus given in R5.
- R7: `q_out` is the top bit of the upper stage. For a nonzero preset with `preset[7]` = 0, it stays low for the whole cycle. Otherwise it is high for (l+1) + (u-8)*M clocks per cycle. For a zero preset this becomes (upper modulus - 8)*M.
- R8: A clock with `rst` high loads the count with the preset, or with 0 when `load_en` is low. After reset, `zero_det` is low.
- R9: The smallest legal ratio is 2, set by preset 8'h02, and it yields a pulse every 2 clocks. A preset of 1 is illegal.
- R10: A digit above 9 on a BCD stage is not a legal preset, but the counter still keeps producing `zero_det` pulses when one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count moves on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| preset | input | 8 | Programmed ratio; [3:0] is the lower digit and [7:4] the upper digit |
| bcd_mode | input | 2 | Per-stage code: 1 = BCD, 0 = binary; bit 0 is the lower stage |
| load_en | input | 1 | High: reload the preset; low: reload zero (full modulus) |
| zero_det | output | 1 | One-clock pulse per completed cycle |
| q_out | output | 1 | Top bit of the upper stage |

## Verification
A wrong count shows up at the ports as a `zero_det` spacing that differs from the reference ratio. The error appears within at most one full cycle, which is 256 clocks in the worst case. A wrong wrap value or a wrong borrow changes both the spacing and the number of clocks that `q_out` is high. Either difference is visible by the end of the current cycle. A wrong reload shows in the very next cycle after the pulse. The bound checker catches these faults one clock after the offending edge.

// File: rtl/dvn_pkg.sv
package dvn_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] digit_t;

  function automatic digit_t digit_top(input logic bcd);
    return bcd ? digit_t'(9) : digit_t'(15);
  endfunction
endpackage

// File: rtl/dvn_digit.sv
module dvn_digit
  import dvn_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bcd,
  input  logic   borrow_in,
  input  logic   load,
  input  digit_t load_val,
  output digit_t value,
  output logic   borrow_out
);
  // A stage at zero that has to borrow wraps to its code's top value.
  // Out-of-range BCD digits simply count down, so nothing locks up.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      value <= load_val;
    end else if (borrow_in) begin
      if (value == '0) value <= digit_top(bcd);
      else             value <= value - digit_t'(1);
    end
  end

  assign borrow_out = borrow_in && (value == '0);
endmodule

// File: rtl/dvn_terminal.sv
module dvn_terminal
  import dvn_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int CW = DIGITS * DIG_W
) (
  input  logic [CW-1:0] count,
  output logic          term
);
  logic [DIGITS-1:0] dig_ok;

  // Terminal state is "1": lowest digit is one, every other digit is zero.
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    if (i == 0) begin : g_low
      assign dig_ok[i] = (count[DIG_W-1:0] == digit_t'(1));
    end else begin : g_up
      assign dig_ok[i] = (count[i*DIG_W +: DIG_W] == '0);
    end
  end

  assign term = &dig_ok;
endmodule

// File: rtl/dvn_load_sel.sv
module dvn_load_sel
  import dvn_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int CW = DIGITS * DIG_W
) (
  input  logic [CW-1:0] preset,
  input  logic          load_en,
  output logic [CW-1:0] load_val
);
  // With loading blocked the chain reloads zero, i.e. runs at full modulus.
  assign load_val = load_en ? preset : '0;
endmodule

// File: rtl/dvn_divider.sv
module dvn_divider
  import dvn_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int CW = DIGITS * DIG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] preset,
  input  logic [DIGITS-1:0] bcd_mode,
  input  logic          load_en,
  output logic          zero_det,
  output logic          q_out
);
  logic [CW-1:0]   count;
  logic [CW-1:0]   load_val;
  logic [DIGITS:0] borrow;
  logic            term;

  assign borrow[0] = 1'b1;

  dvn_load_sel #(.DIGITS(DIGITS)) load_sel_i (
    .preset   (preset),
    .load_en  (load_en),
    .load_val (load_val)
  );

  for (genvar i = 0; i < DIGITS; i++) begin : g_stage
    dvn_digit digit_i (
      .clk        (clk),
      .rst        (rst),
      .bcd        (bcd_mode[i]),
      .borrow_in  (borrow[i]),
      .load       (term),
      .load_val   (load_val[i*DIG_W +: DIG_W]),
      .value      (count[i*DIG_W +: DIG_W]),
      .borrow_out (borrow[i+1])
    );
  end

  dvn_terminal #(.DIGITS(DIGITS)) terminal_i (
    .count (count),
    .term  (term)
  );

  assign zero_det = term;
  assign q_out    = count[CW-1];
endmodule

// File: rtl/dvn_divider_chk.sv
module dvn_divider_chk #(
  parameter int DIGITS = 2,
  localparam int CW = DIGITS * 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     preset,
  input logic [DIGITS-1:0] bcd_mode,
  input logic              load_en,
  input logic              zero_det,
  input logic              q_out,
  input logic [CW-1:0]     count
);
  assert_lower_dec_R1: assert property (@(posedge clk) disable iff (rst)
    (!zero_det && count[3:0] != 4'd0) |=> count[3:0] == $past(count[3:0]) - 4'd1);

  assert_upper_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!zero_det && count[3:0] != 4'd0) |=> $stable(count[CW-1:4]));

  assert_lower_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!zero_det && count[3:0] == 4'd0) |=>
      count[3:0] == ($past(bcd_mode[0]) ? 4'd9 : 4'd15));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (zero_det && !(load_en && preset == CW'(1))) |=> !zero_det);

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    zero_det |=> count == $past(load_en ? preset : '0));

  assert_q_reload_R7: assert property (@(posedge clk) disable iff (rst)
    zero_det |=> q_out == $past(load_en & preset[CW-1]));
endmodule

bind dvn_divider dvn_divider_chk #(.DIGITS(DIGITS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .preset   (preset),
  .bcd_mode (bcd_mode),
  .load_en  (load_en),
  .zero_det (zero_det),
  .q_out    (q_out),
  .count    (count)
);

// File: tb/dvn_divider_tb_top.sv
module dvn_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] preset = 8'h02;
  logic [1:0] bcd_mode = 2'b00;
  logic       load_en = 1'b1;
  logic       zero_det;
  logic       q_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dvn_divider dut_i (
    .clk(clk), .rst(rst), .preset(preset), .bcd_mode(bcd_mode),
    .load_en(load_en), .zero_det(zero_det), .q_out(q_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_mod(input logic [1:0] m);
    return m[0] ? 10 : 16;
  endfunction

  function automatic int up_mod(input logic [1:0] m);
    return m[1] ? 10 : 16;
  endfunction

  function automatic int ref_ratio(input logic [7:0] p, input logic [1:0] m);
    if (p == 8'h00) return low_mod(m) * up_mod(m);
    return int'(p[7:4]) * low_mod(m) + int'(p[3:0]);
  endfunction

  function automatic int ref_qhigh(input logic [7:0] p, input logic [1:0] m);
    if (p == 8'h00) return (up_mod(m) - 8) * low_mod(m);
    if (!p[7]) return 0;
    return int'(p[3:0]) + 1 + (int'(p[7:4]) - 8) * low_mod(m);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Measures one full cycle, from just after a pulse up to and including the next.
  task automatic measure(output int per, output int zd_hi, output int q_hi);
    int n;
    per = -1; zd_hi = 0; q_hi = 0;
    n = 0;
    while (zero_det !== 1'b1 && n < 600) begin
      @(negedge clk); n++;
    end
    if (n >= 600) return;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (zero_det === 1'b1) zd_hi++;
      if (q_out === 1'b1) q_hi++;
    end while (zero_det !== 1'b1 && n < 600);
    if (zero_det === 1'b1) per = n;
  endtask

  task automatic run_ratio(input logic [7:0] p, input logic [1:0] m, input string tag);
    int per, zh, qh;
    @(negedge clk);
    preset = p; bcd_mode = m; load_en = 1'b1;
    do_reset();
    measure(per, zh, qh);
    check(per == ref_ratio(p, m), tag, per, ref_ratio(p, m));
    check(zh == 1, "R4 pulse width", zh, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    preset = 8'h95; bcd_mode = 2'b00; load_en = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    check(zero_det == 1'b0, "R8 zero_det in reset", zero_det, 0);
    check(q_out == 1'b1, "R8 count loaded with preset", q_out, 1);
    load_en = 1'b0;
    @(negedge clk);
    check(q_out == 1'b0, "R8 count loaded with zero", q_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(zero_det == 1'b0, "R8 zero_det after reset", zero_det, 0);
  endtask

  task automatic t_min_ratio();
    for (int m = 0; m < 4; m++) run_ratio(8'h02, 2'(m), "R9 min ratio");
    run_ratio(8'h03, 2'b11, "R3 ratio three");
    run_ratio(8'h04, 2'b00, "R3 ratio four");
    run_ratio(8'h12, 2'b11, "R3 ratio twelve");
  endtask

  task automatic t_max_modulus();
    for (int m = 0; m < 4; m++) run_ratio(8'h00, 2'(m), "R5 zero preset modulus");
  endtask

  task automatic t_random();
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] p;
        do begin
          p[3:0] = 4'($urandom_range(low_mod(2'(m)) - 1));
          p[7:4] = 4'($urandom_range(up_mod(2'(m)) - 1));
        end while (p < 8'h02);
        run_ratio(p, 2'(m), m[0] ? "R2 R3 bcd-lower ratio" : "R2 R3 bin-lower ratio");
      end
    end
  endtask

  task automatic t_cascade();
    int per, zh, qh;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      preset = 8'h37; bcd_mode = 2'(m); load_en = 1'b0;
      do_reset();
      measure(per, zh, qh);
      check(per == ref_ratio(8'h00, 2'(m)), "R6 preset ignored", per, ref_ratio(8'h00, 2'(m)));
      preset = 8'h05;
      measure(per, zh, qh);
      check(per == ref_ratio(8'h00, 2'(m)), "R6 preset change ignored", per,
            ref_ratio(8'h00, 2'(m)));
    end
    load_en = 1'b1;
  endtask

  task automatic t_q();
    logic [7:0] plist [5] = '{8'h5A, 8'h95, 8'hC8, 8'h00, 8'h85};
    logic [1:0] mlist [5] = '{2'b00, 2'b11, 2'b00, 2'b10, 2'b01};
    for (int k = 0; k < 5; k++) begin
      int per, zh, qh;
      @(negedge clk);
      preset = plist[k]; bcd_mode = mlist[k]; load_en = 1'b1;
      do_reset();
      measure(per, zh, qh);
      check(qh == ref_qhigh(plist[k], mlist[k]), "R7 q_out high clocks", qh,
            ref_qhigh(plist[k], mlist[k]));
    end
  endtask

  task automatic t_bad_bcd();
    int per, zh, qh;
    @(negedge clk);
    preset = 8'hC5; bcd_mode = 2'b11; load_en = 1'b1;
    do_reset();
    measure(per, zh, qh);
    check(per > 0, "R10 no lockup on bad BCD digit", per, 1);
    measure(per, zh, qh);
    check(per > 0 && zh == 1, "R10 pulses continue", per, 1);
  endtask

  initial begin
    t_reset();
    t_min_ratio();
    t_max_modulus();
    t_random();
    t_cascade();
    t_q();
    t_bad_bcd();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule